// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block is the sending half of a full-duplex asynchronous serial port. Software, or a bus register block in front of it, writes a data word into a one-deep holding register. When the line is free the word moves into a shift register and leaves on the serial line, least significant bit first. The frame has a start bit, the data bits, an optional ninth bit, an optional parity bit computed in hardware, and a stop bit. The ninth bit comes from a sticky register that is written separately and is reused for every frame until it is rewritten.

The block can also send break characters, which are runs of zeros. A single pulse on the break request sends one break. Holding the request high sends zeros without a gap, and the break in progress still finishes after the request is released. Whenever the transmit enable rises, the block sends one idle character of all ones before any queued data. The whole serial output can be inverted. Two status flags are provided, one for an empty holding register and one for a finished transmission. Each flag has an interrupt request gated by its own enable. The bit rate comes from an external tick at sixteen times the bit rate, so the baud divisor is outside this block.

Top module: `uatx_top`

## Requirements
- R1: With `tx_en` high, `txd` idles at 1 (polarity not inverted). A data frame is a 0 start bit, then the DATA_W data bits least significant bit first, then a 1 stop bit. Every bit lasts OVS `baud_tick` pulses, which is 16 by default.
- R2: When `nine_mode` is 1, one extra bit follows the last data bit. Its value is the sticky ninth-bit register, which `bit8_wr`/`bit8_val` loads and which stays unchanged across any number of frames.
- R3: When `par_en` is 1, a parity bit is placed after the data bits and after the ninth bit if one is present, just before the stop bit. The parity covers the data bits and the ninth bit, and the ones count is even when `par_odd`=0 and odd when `par_odd`=1.
- R4: `hold_empty` is 1 after reset. It drops in the cycle after a `wr_stb` and returns to 1 when the held word moves into the shift register. A word written while a frame is on the line stays held until that frame's stop bit ends.
- R5: `xmit_done` is 1 after reset. A `wr_stb` that comes after a `status_rd` pulse clears it. A `wr_stb` with no `status_rd` before it leaves it unchanged. It returns to 1 once the transmitter is idle with no word, break or idle character pending.
- R6: `irq_hold_empty` equals `hold_empty` AND `ie_hold_empty`. `irq_xmit_done` equals `xmit_done` AND `ie_xmit_done`.
- R7: While `brk_req` is held at 1, `txd` sends zeros without a gap. After release, the break character in progress completes before the line returns to 1.
- R8: A single-cycle `brk_req` pulse sends exactly DATA_W+2 zero bits, plus 1 when `nine_mode`=1, plus 3 when `brk_long`=1. With defaults this is 10, 11, 13 or 14 bits.
- R9: A 0-to-1 edge of `tx_en` sends one idle character before any queued word. The idle character is all ones and as long as a data frame in the current format.
- R10: `inv_out`=1 inverts every level on `txd`, including the idle level.
- R11: While `tx_en` is 0, `txd` sits at the idle level, an in-progress frame is dropped, and a held word stays in the holding register (`hold_empty` stays 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One pulse per oversample period (OVS per bit) |
| tx_en | input | 1 | Transmitter enable; a rising edge queues an idle character |
| nine_mode | input | 1 | Insert the ninth bit after the data bits |
| par_en | input | 1 | Insert a hardware parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| brk_req | input | 1 | Break request, as a pulse or held |
| brk_long | input | 1 | Lengthen each break by three bits |
| inv_out | input | 1 | Invert the serial output |
| wr_stb | input | 1 | Write `wr_data` into the holding register |
| wr_data | input | DATA_W | Data word to send |
| bit8_wr | input | 1 | Load the sticky ninth bit |
| bit8_val | input | 1 | Value for the sticky ninth bit |
| status_rd | input | 1 | Status read strobe; arms the clearing of `xmit_done` |
| ie_hold_empty | input | 1 | Interrupt enable for `hold_empty` |
| ie_xmit_done | input | 1 | Interrupt enable for `xmit_done` |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a word |
| xmit_done | output | 1 | Transmission complete flag |
| irq_hold_empty | output | 1 | Interrupt request for the empty holding register |
| irq_xmit_done | output | 1 | Interrupt request for transmission complete |

## Verification
The bench builds the block with its defaults: eight data bits, sixteen ticks per bit and a registered output stage. This means every frame length from ten to twelve bits and every break length from ten to fourteen zeros gets measured in clock cycles. The bench also runs one pass with the tick gated to every other cycle, which shows that bit timing follows the tick rather than the clock. The registered output adds one cycle of fixed latency. The idle-character check allows for that cycle and still tells a preamble apart from data sent at once.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

   typedef enum logic [1:0] {
      FK_IDLE = 2'd0,
      FK_DATA = 2'd1,
      FK_BRK  = 2'd2,
      FK_PRE  = 2'd3
   } frame_kind_e;

   // Parity bit from the xor of all covered bits: even -> xor, odd -> inverse
   function automatic logic par_bit(input logic ones_xor, input logic odd_sel);
      return ones_xor ^ odd_sel;
   endfunction

endpackage

// File: rtl/uatx_hold.sv
module uatx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bit8_wr,
   input  logic              bit8_val,
   input  logic              load,
   input  logic              status_rd,
   input  logic              busy,
   input  logic              ie_hold_empty,
   input  logic              ie_xmit_done,
   output logic [DATA_W-1:0] hold_data,
   output logic              bit8_q,
   output logic              hold_full,
   output logic              hold_empty,
   output logic              xmit_done,
   output logic              irq_hold_empty,
   output logic              irq_xmit_done
);

   logic armed;
   logic tc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data <= '0;
         hold_full <= 1'b0;
         bit8_q    <= 1'b0;
         armed     <= 1'b0;
         tc_q      <= 1'b1;
      end else begin
         if (wr_stb) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
         end else if (load) begin
            hold_full <= 1'b0;
         end
         if (bit8_wr)
            bit8_q <= bit8_val;
         if (wr_stb)
            armed <= 1'b0;
         else if (status_rd)
            armed <= 1'b1;
         if (armed && wr_stb)
            tc_q <= 1'b0;
         else if (!busy && !hold_full)
            tc_q <= 1'b1;
      end
   end

   assign hold_empty     = !hold_full;
   assign xmit_done      = tc_q;
   assign irq_hold_empty = hold_empty & ie_hold_empty;
   assign irq_xmit_done  = tc_q & ie_xmit_done;

   AST_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr_stb) |=> hold_empty);  // R4
   AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !hold_empty);  // R4
   AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_stb) |=> !xmit_done);  // R5
   AST_DONE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && xmit_done) |=> xmit_done);  // R5
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_xmit_done |-> !irq_xmit_done);  // R6

endmodule

// File: rtl/uatx_framer.sv
module uatx_framer import uatx_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int VEC_W  = DATA_W + 6,
   parameter int LEN_W  = $clog2(VEC_W + 1)
) (
   input  logic [DATA_W-1:0] data,
   input  logic              bit8,
   input  logic              nine_mode,
   input  logic              par_en,
   input  logic              par_odd,
   output logic [VEC_W-1:0]  vec,
   output logic [LEN_W-1:0]  len
);

   if (VEC_W < DATA_W + 4) begin : g_bad_vec
      $error("uatx_framer: VEC_W too small for the longest frame");
   end

   // Running xor over the data bits
   logic [DATA_W:0] chain;
   assign chain[0] = 1'b0;
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_xor
      assign chain[gi+1] = chain[gi] ^ data[gi];
   end

   logic [LEN_W-1:0] pos;

   always_comb begin
      vec    = '1;
      vec[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
         vec[i+1] = data[i];
      pos = LEN_W'(DATA_W + 1);
      if (nine_mode) begin
         vec[pos] = bit8;
         pos      = pos + LEN_W'(1);
      end
      if (par_en) begin
         vec[pos] = par_bit(chain[DATA_W] ^ (nine_mode & bit8), par_odd);
         pos      = pos + LEN_W'(1);
      end
      // stop bit at pos stays 1
      len = pos + LEN_W'(1);
   end

endmodule

// File: rtl/uatx_bit_timer.sv
module uatx_bit_timer #(
   parameter int OVS   = 16,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic             baud_tick,
   input  logic [LEN_W-1:0] len,
   output logic             bit_adv,
   output logic             frame_end
);

   localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

   if (OVS < 2) begin : g_bad_ovs
      $error("uatx_bit_timer: OVS must be at least 2");
   end

   logic [SUB_W-1:0] sub;
   logic [LEN_W-1:0] bcnt;

   assign bit_adv   = active && baud_tick && (sub == SUB_W'(OVS - 1));
   assign frame_end = bit_adv && (bcnt == len - LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub  <= '0;
         bcnt <= '0;
      end else if (start || !active) begin
         sub  <= '0;
         bcnt <= '0;
      end else if (bit_adv) begin
         sub  <= '0;
         bcnt <= bcnt + LEN_W'(1);
      end else if (baud_tick) begin
         sub  <= sub + SUB_W'(1);
      end
   end

   AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (bcnt < len));  // R1
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !baud_tick && !start) |=> $stable(sub));  // R1

endmodule

// File: rtl/uatx_top.sv
module uatx_top import uatx_pkg::*; #(
   parameter int DATA_W  = 8,
   parameter int OVS     = 16,
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_en,
   input  logic              nine_mode,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              brk_req,
   input  logic              brk_long,
   input  logic              inv_out,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bit8_wr,
   input  logic              bit8_val,
   input  logic              status_rd,
   input  logic              ie_hold_empty,
   input  logic              ie_xmit_done,
   output logic              txd,
   output logic              hold_empty,
   output logic              xmit_done,
   output logic              irq_hold_empty,
   output logic              irq_xmit_done
);

   localparam int VEC_W = DATA_W + 6;
   localparam int LEN_W = $clog2(VEC_W + 1);

   if (DATA_W < 1) begin : g_bad_width
      $error("uatx_top: DATA_W must be positive");
   end

   frame_kind_e       kind;
   logic [VEC_W-1:0]  shreg;
   logic [LEN_W-1:0]  len_q;
   logic              en_q, brk_q;
   logic              pre_pend, brk_pend;
   logic [DATA_W-1:0] hold_data;
   logic              bit8_q, hold_full;
   logic [VEC_W-1:0]  dat_vec;
   logic [LEN_W-1:0]  dat_len;
   logic [LEN_W-1:0]  brk_len;
   logic              bit_adv, frame_end;
   logic              slot, want_brk, want_pre;
   logic              start_brk, start_pre, start_dat, start_any;
   logic              busy, raw_lvl, out_lvl;

   uatx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_stb), .wr_data(wr_data),
      .bit8_wr(bit8_wr), .bit8_val(bit8_val),
      .load(start_dat), .status_rd(status_rd), .busy(busy),
      .ie_hold_empty(ie_hold_empty), .ie_xmit_done(ie_xmit_done),
      .hold_data(hold_data), .bit8_q(bit8_q), .hold_full(hold_full),
      .hold_empty(hold_empty), .xmit_done(xmit_done),
      .irq_hold_empty(irq_hold_empty), .irq_xmit_done(irq_xmit_done)
   );

   uatx_framer #(.DATA_W(DATA_W), .VEC_W(VEC_W), .LEN_W(LEN_W)) u_framer (
      .data(hold_data), .bit8(bit8_q), .nine_mode(nine_mode),
      .par_en(par_en), .par_odd(par_odd), .vec(dat_vec), .len(dat_len)
   );

   uatx_bit_timer #(.OVS(OVS), .LEN_W(LEN_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start_any),
      .active(kind != FK_IDLE), .baud_tick(baud_tick), .len(len_q),
      .bit_adv(bit_adv), .frame_end(frame_end)
   );

   // Break length follows the frame length; long option adds three bits
   assign brk_len = LEN_W'(DATA_W + 2) + LEN_W'(nine_mode)
                  + (brk_long ? LEN_W'(3) : LEN_W'(0));

   // Start arbitration: break, then idle character, then data
   assign slot      = tx_en && ((kind == FK_IDLE) || frame_end);
   assign want_brk  = brk_pend || brk_req;
   assign want_pre  = pre_pend || (tx_en && !en_q);
   assign start_brk = slot && want_brk;
   assign start_pre = slot && !want_brk && want_pre;
   assign start_dat = slot && !want_brk && !want_pre && hold_full;
   assign start_any = start_brk || start_pre || start_dat;

   assign busy = (kind != FK_IDLE) || brk_pend || pre_pend || brk_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         brk_q    <= 1'b0;
         pre_pend <= 1'b0;
         brk_pend <= 1'b0;
         kind     <= FK_IDLE;
         shreg    <= '1;
         len_q    <= '0;
      end else begin
         en_q  <= tx_en;
         brk_q <= brk_req;
         if (!tx_en)
            brk_pend <= 1'b0;
         else if (start_brk)
            brk_pend <= 1'b0;
         else if (brk_req && !brk_q)
            brk_pend <= 1'b1;
         if (!tx_en)
            pre_pend <= 1'b0;
         else if (start_pre)
            pre_pend <= 1'b0;
         else if (!en_q)
            pre_pend <= 1'b1;
         if (!tx_en) begin
            kind  <= FK_IDLE;
            shreg <= '1;
         end else if (start_brk) begin
            kind  <= FK_BRK;
            shreg <= '0;
            len_q <= brk_len;
         end else if (start_pre) begin
            kind  <= FK_PRE;
            shreg <= '1;
            len_q <= dat_len;
         end else if (start_dat) begin
            kind  <= FK_DATA;
            shreg <= dat_vec;
            len_q <= dat_len;
         end else if (frame_end) begin
            kind  <= FK_IDLE;
            shreg <= '1;
         end else if (bit_adv) begin
            shreg <= {1'b1, shreg[VEC_W-1:1]};
         end
      end
   end

   assign raw_lvl = (kind == FK_IDLE) ? 1'b1 : shreg[0];
   assign out_lvl = raw_lvl ^ inv_out;

   if (REG_OUT != 0) begin : g_reg_out
      logic txd_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            txd_r <= 1'b1;
         else
            txd_r <= out_lvl;
      end
      assign txd = txd_r;
   end else begin : g_comb_out
      assign txd = out_lvl;
   end

   AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FK_BRK) |-> !raw_lvl);  // R7
   AST_PREAMBLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FK_PRE) |-> raw_lvl);  // R9
   AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (raw_lvl && kind == FK_IDLE));  // R11
   AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && kind != FK_IDLE && !bit_adv) |=> $stable(raw_lvl));  // R1
   AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_brk, start_pre, start_dat}));  // R9

endmodule

// File: tb/test_uatx_top.sv
module test_uatx_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic       slow_tick = 1'b0;
   logic       tx_en = 1'b0, nine_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0;
   logic       brk_req = 1'b0, brk_long = 1'b0, inv_out = 1'b0;
   logic       wr_stb = 1'b0, bit8_wr = 1'b0, bit8_val = 1'b0, status_rd = 1'b0;
   logic [7:0] wr_data = '0;
   logic       ie_hold_empty = 1'b0, ie_xmit_done = 1'b0;
   logic       txd, hold_empty, xmit_done, irq_hold_empty, irq_xmit_done;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   always @(negedge clk) baud_tick <= slow_tick ? ~baud_tick : 1'b1;

   uatx_top i_uatx_top (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
      .nine_mode(nine_mode), .par_en(par_en), .par_odd(par_odd),
      .brk_req(brk_req), .brk_long(brk_long), .inv_out(inv_out),
      .wr_stb(wr_stb), .wr_data(wr_data), .bit8_wr(bit8_wr), .bit8_val(bit8_val),
      .status_rd(status_rd), .ie_hold_empty(ie_hold_empty), .ie_xmit_done(ie_xmit_done),
      .txd(txd), .hold_empty(hold_empty), .xmit_done(xmit_done),
      .irq_hold_empty(irq_hold_empty), .irq_xmit_done(irq_xmit_done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic write_word(input logic [7:0] d, input bit armed);
      if (armed) begin
         status_rd = 1'b1;
         @(negedge clk);
         status_rd = 1'b0;
      end
      wr_data = d;
      wr_stb  = 1'b1;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic set_bit8(input logic v);
      bit8_val = v;
      bit8_wr  = 1'b1;
      @(negedge clk);
      bit8_wr  = 1'b0;
   endtask

   task automatic wait_start(input logic idle_lvl, output int cyc);
      cyc = 0;
      while (txd == idle_lvl && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
      if (cyc >= 3000) chk(1'b0, "start bit timeout", cyc, 0);
   endtask

   task automatic grab(input int n, input logic inv, input int per, output logic [15:0] b);
      b = '0;
      repeat (per / 2) @(negedge clk);
      b[0] = txd ^ inv;
      for (int i = 1; i < n; i++) begin
         repeat (per) @(negedge clk);
         b[i] = txd ^ inv;
      end
   endtask

   function automatic logic [15:0] exp_frame(input logic [7:0] d, input logic nine,
                                             input logic b8, input logic pe, input logic po);
      logic [15:0] f;
      int p;
      logic x;
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++) f[i+1] = d[i];
      p = 9;
      x = ^d;
      if (nine) begin f[p] = b8; x = x ^ b8; p++; end
      if (pe) begin f[p] = x ^ po; p++; end
      f[p] = 1'b1;
      return f;
   endfunction

   task automatic send_check(input logic [7:0] d, input string tag);
      logic [15:0] got, exp;
      int n, cyc;
      n = 10 + int'(nine_mode) + int'(par_en);
      exp = exp_frame(d, nine_mode, bit8_val, par_en, par_odd);
      write_word(d, 1'b0);
      wait_start(~inv_out, cyc);
      grab(n, inv_out, 16, got);
      for (int i = 0; i < n; i++)
         chk(got[i] == exp[i], tag, int'(got[i]), int'(exp[i]));
      repeat (12) @(negedge clk);
   endtask

   task automatic measure_low(output int n);
      int cyc;
      wait_start(1'b1, cyc);
      n = 1;
      @(negedge clk);
      while (txd == 1'b0 && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk(txd == 1'b1, "R1 idle level after reset", int'(txd), 1);
      chk(hold_empty == 1'b1, "R4 hold_empty after reset", int'(hold_empty), 1);
      chk(xmit_done == 1'b1, "R5 xmit_done after reset", int'(xmit_done), 1);
      chk(irq_hold_empty == 1'b0 && irq_xmit_done == 1'b0, "R6 irqs masked",
          int'(irq_hold_empty | irq_xmit_done), 0);
   endtask

   task automatic t_disabled_then_preamble;
      logic [15:0] got, exp;
      int cyc;
      write_word(8'h3C, 1'b0);
      repeat (40) @(negedge clk);
      chk(txd == 1'b1, "R11 line idle while disabled", int'(txd), 1);
      chk(hold_empty == 1'b0, "R11 word held while disabled", int'(hold_empty), 0);
      tx_en = 1'b1;
      wait_start(1'b1, cyc);
      chk(cyc >= 160 && cyc <= 164, "R9 idle character before data", cyc, 162);
      exp = exp_frame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
      grab(10, 1'b0, 16, got);
      chk(got[9:0] == exp[9:0], "R9 queued word after preamble", int'(got[9:0]), int'(exp[9:0]));
      repeat (12) @(negedge clk);
   endtask

   task automatic t_basic;
      logic [15:0] got, exp;
      int cyc;
      write_word(8'hA5, 1'b1);
      chk(hold_empty == 1'b0, "R4 hold_empty drops on write", int'(hold_empty), 0);
      chk(xmit_done == 1'b0, "R5 armed write clears xmit_done", int'(xmit_done), 0);
      @(negedge clk);
      chk(hold_empty == 1'b1, "R4 hold_empty after load", int'(hold_empty), 1);
      wait_start(1'b1, cyc);
      grab(10, 1'b0, 16, got);
      exp = exp_frame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
      chk(got[9:0] == exp[9:0], "R1 frame 0xA5", int'(got[9:0]), int'(exp[9:0]));
      chk(xmit_done == 1'b0, "R5 xmit_done low during frame", int'(xmit_done), 0);
      repeat (20) @(negedge clk);
      chk(xmit_done == 1'b1, "R5 xmit_done after frame", int'(xmit_done), 1);
      send_check(8'h01, "R1 frame 0x01");
   endtask

   task automatic t_unarmed;
      int cyc;
      logic [15:0] got;
      write_word(8'h77, 1'b0);
      chk(xmit_done == 1'b1, "R5 unarmed write keeps xmit_done", int'(xmit_done), 1);
      wait_start(1'b1, cyc);
      grab(10, 1'b0, 16, got);
      repeat (12) @(negedge clk);
   endtask

   task automatic t_back_to_back;
      logic [15:0] ga, gb, ea, eb;
      int c1, c2;
      ea = exp_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0);
      eb = exp_frame(8'h3E, 1'b0, 1'b0, 1'b0, 1'b0);
      write_word(8'h96, 1'b0);
      fork
         begin
            wait_start(1'b1, c1);
            grab(10, 1'b0, 16, ga);
            wait_start(1'b1, c2);
            chk(c2 <= 9, "R4 second word follows stop bit", c2, 8);
            grab(10, 1'b0, 16, gb);
         end
         begin
            repeat (20) @(negedge clk);
            write_word(8'h3E, 1'b0);
            repeat (80) @(negedge clk);
            chk(hold_empty == 1'b0, "R4 word waits during frame", int'(hold_empty), 0);
         end
      join
      chk(ga[9:0] == ea[9:0], "R4 first word", int'(ga[9:0]), int'(ea[9:0]));
      chk(gb[9:0] == eb[9:0], "R4 second word", int'(gb[9:0]), int'(eb[9:0]));
      chk(hold_empty == 1'b1, "R4 empty after second load", int'(hold_empty), 1);
      repeat (12) @(negedge clk);
   endtask

   task automatic t_ninth;
      nine_mode = 1'b1;
      set_bit8(1'b1);
      send_check(8'h0F, "R2 ninth bit first frame");
      send_check(8'hF0, "R2 ninth bit reused");
      set_bit8(1'b0);
      send_check(8'h55, "R2 ninth bit rewritten");
      nine_mode = 1'b0;
   endtask

   task automatic t_parity;
      par_en = 1'b1;
      par_odd = 1'b0;
      send_check(8'hA5, "R3 even parity 4 ones");
      send_check(8'hA4, "R3 even parity 3 ones");
      par_odd = 1'b1;
      send_check(8'hA5, "R3 odd parity");
      par_odd = 1'b0;
      nine_mode = 1'b1;
      set_bit8(1'b1);
      send_check(8'hA5, "R3 parity covers ninth bit");
      nine_mode = 1'b0;
      par_en = 1'b0;
   endtask

   task automatic pulse_break(input int exp, input string tag);
      int n;
      brk_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0;
      measure_low(n);
      chk(n == exp, tag, n, exp);
      repeat (10) @(negedge clk);
   endtask

   task automatic t_break_pulse;
      pulse_break(160, "R8 break 10 bits");
      nine_mode = 1'b1;
      pulse_break(176, "R8 break 11 bits");
      brk_long = 1'b1;
      pulse_break(224, "R8 long break 14 bits");
      nine_mode = 1'b0;
      pulse_break(208, "R8 long break 13 bits");
      brk_long = 1'b0;
   endtask

   task automatic t_break_held;
      int n, cyc;
      brk_req = 1'b1;
      wait_start(1'b1, cyc);
      n = 1;
      @(negedge clk);
      while (txd == 1'b0 && n < 5000) begin
         n++;
         if (n == 400) brk_req = 1'b0;
         @(negedge clk);
      end
      chk(n == 480, "R7 held break completes frame", n, 480);
      repeat (10) @(negedge clk);
   endtask

   task automatic t_polarity;
      inv_out = 1'b1;
      repeat (3) @(negedge clk);
      chk(txd == 1'b0, "R10 inverted idle level", int'(txd), 0);
      send_check(8'h5A, "R10 inverted frame");
      inv_out = 1'b0;
      repeat (3) @(negedge clk);
      chk(txd == 1'b1, "R10 normal idle level", int'(txd), 1);
   endtask

   task automatic t_slow_tick;
      int n;
      slow_tick = 1'b1;
      repeat (4) @(negedge clk);
      write_word(8'h00, 1'b0);
      measure_low(n);
      chk(n == 288, "R1 bit length follows tick", n, 288);
      repeat (40) @(negedge clk);
      slow_tick = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_irq;
      ie_hold_empty = 1'b1;
      ie_xmit_done = 1'b1;
      @(negedge clk);
      chk(irq_hold_empty == 1'b1, "R6 irq_hold_empty idle", int'(irq_hold_empty), 1);
      chk(irq_xmit_done == 1'b1, "R6 irq_xmit_done idle", int'(irq_xmit_done), 1);
      write_word(8'hC3, 1'b1);
      chk(irq_hold_empty == 1'b0, "R6 irq_hold_empty after write", int'(irq_hold_empty), 0);
      chk(irq_xmit_done == 1'b0, "R6 irq_xmit_done after write", int'(irq_xmit_done), 0);
      repeat (200) @(negedge clk);
      chk(irq_xmit_done == 1'b1, "R6 irq_xmit_done after frame", int'(irq_xmit_done), 1);
      ie_hold_empty = 1'b0;
      ie_xmit_done = 1'b0;
      @(negedge clk);
      chk(irq_hold_empty == 1'b0 && irq_xmit_done == 1'b0, "R6 irqs masked again",
          int'(irq_hold_empty | irq_xmit_done), 0);
   endtask

   task automatic t_disable_mid;
      int cyc;
      write_word(8'h00, 1'b0);
      wait_start(1'b1, cyc);
      repeat (40) @(negedge clk);
      tx_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(txd == 1'b1, "R11 disable drops frame", int'(txd), 1);
      repeat (60) @(negedge clk);
      chk(txd == 1'b1, "R11 line stays idle", int'(txd), 1);
      tx_en = 1'b1;
      repeat (200) @(negedge clk);
      chk(txd == 1'b1, "R11 no resend after enable", int'(txd), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled_then_preamble();
      t_basic();
      t_unarmed();
      t_back_to_back();
      t_ninth();
      t_parity();
      t_break_pulse();
      t_break_held();
      t_polarity();
      t_slow_tick();
      t_irq();
      t_disable_mid();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule